// File: doc/BRIEF.md
# Dual-Strobe Burst Address Sequencer

This block sits in front of a synchronous cache data array and supplies the word address for every beat of a four-beat burst. A burst opens when either of two active-low strobes is sampled low at a rising clock edge: one strobe comes from the processor and the other from the cache controller. On that edge the whole word address is captured. Its two low bits seed a small wraparound counter, and the upper bits are frozen for the rest of the burst.

After the opening edge, an active-low advance input moves the counter one beat per clock. The beat order is linear (add one, modulo four) or interleaved (start offset XOR beat number), chosen by an order input or fixed by a parameter. Three chip enables, one active high and two active low, qualify the opening of a burst. A strobe seen while the block is not fully selected closes any running burst. The processor strobe has priority over the controller strobe, and it is masked whenever the first chip enable is inactive. Once a burst is running, continue and hold cycles ignore the chip enables.

Outputs are the current array address, a flag showing that a burst is active, and a flag telling whether the processor strobe opened the current burst.

Top module: `burst_addr_seq`

## Requirements
- R1: A synchronous reset, active high, clears `addr_out` to zero and clears both `active` and `proc_owned`.
- R2: A strobe accepted while `sel1_n`=0, `sel2`=1 and `sel3_n`=0 loads all bits of `addr_in` into `addr_out` and sets `active`. The new value is visible after that clock edge.
- R3: When both strobes are low and `sel1_n`=0, the processor strobe is the one acted on, so `proc_owned` becomes 1. A burst opened by the controller strobe alone sets `proc_owned` to 0.
- R4: While `sel1_n`=1, a low `proc_stb_n` has no effect. With the controller strobe high, the address and `active` behave exactly as if no strobe were present.
- R5: A strobe that is acted on while the block is not fully selected clears `active` and `proc_owned` and leaves `addr_out` unchanged.
- R6: With `order_sel`=1 (interleaved), the low two address bits at beat k equal the start offset XOR k.
- R7: With `order_sel`=0 (linear), the low two address bits at beat k equal the start offset plus k, modulo 4.
- R8: With no strobe acted on and `adv_n`=1, `addr_out` holds its value, so the burst is suspended.
- R9: Continue and suspend cycles behave the same whatever the values of `sel1_n`, `sel2` and `sel3_n`.
- R10: During a burst only bits [1:0] of `addr_out` change. After four advances the address returns to the start address.
- R11: While `active`=0, `adv_n`=0 does not change `addr_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| proc_stb_n | input | 1 | Processor burst strobe, active low, has priority |
| ctrl_stb_n | input | 1 | Cache-controller burst strobe, active low |
| adv_n | input | 1 | Advance to the next beat, active low |
| order_sel | input | 1 | 1 = interleaved order, 0 = linear order |
| sel1_n | input | 1 | Chip enable 1, active low, also masks the processor strobe |
| sel2 | input | 1 | Chip enable 2, active high |
| sel3_n | input | 1 | Chip enable 3, active low |
| addr_in | input | 17 | Word address offered at the start of a burst |
| addr_out | output | 17 | Current array address |
| active | output | 1 | A selected burst is in progress |
| proc_owned | output | 1 | The current burst was opened by the processor strobe |

## Verification
Every result is registered once, so any load, step, hold or deselect caused by inputs sampled at rising edge n is visible on the outputs right after edge n. The order input acts combinationally on the low two bits. The bench drives inputs on falling edges and checks the outputs a short delay after the following rising edge. Each expected value therefore belongs to exactly one sampled input set. It sweeps both orders, both strobes and all four start offsets over five beats, with a suspend inserted and the chip enables scrambled, and computes each expected offset arithmetically from the start offset and the beat number.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
   // What the strobe and chip-enable decode asks the sequencer to do this cycle.
   typedef enum logic [1:0] {
      CYC_NONE  = 2'd0,   // no strobe acted on: continue or suspend
      CYC_LOAD  = 2'd1,   // selected start of a burst
      CYC_DESEL = 2'd2    // strobe while deselected: close the burst
   } cyc_kind_e;

   // Burst order choice: taken from the pin or fixed at build time.
   localparam int ORDER_FROM_PIN = 0;
   localparam int ORDER_LINEAR   = 1;
   localparam int ORDER_XOR      = 2;
endpackage

// File: rtl/burst_strobe_arb.sv
module burst_strobe_arb
   import burst_seq_pkg::*;
(
   input  logic      proc_stb_n,
   input  logic      ctrl_stb_n,
   input  logic      sel1_n,
   input  logic      sel2,
   input  logic      sel3_n,
   output cyc_kind_e kind,
   output logic      from_proc
);
   logic proc_seen;
   logic ctrl_seen;
   logic selected;

   // The processor strobe is masked by the first chip enable and wins over the controller.
   assign proc_seen = !proc_stb_n && !sel1_n;
   assign ctrl_seen = !ctrl_stb_n && !proc_seen;
   assign selected  = !sel1_n && sel2 && !sel3_n;
   assign from_proc = proc_seen;

   always_comb begin
      kind = CYC_NONE;
      if (proc_seen || ctrl_seen) begin
         kind = selected ? CYC_LOAD : CYC_DESEL;
      end
   end
endmodule

// File: rtl/burst_wrap_ctr.sv
module burst_wrap_ctr
   import burst_seq_pkg::*;
#(
   parameter int BURST_W   = 2,
   parameter int ORDER_SRC = ORDER_FROM_PIN
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               load,
   input  logic [BURST_W-1:0] seed,
   input  logic               step,
   input  logic               order_sel,
   output logic [BURST_W-1:0] offset
);
   localparam logic [BURST_W-1:0] ONE = BURST_W'(1);

   logic [BURST_W-1:0] seed_q;
   logic [BURST_W-1:0] beat_q;
   logic               use_xor;

   generate
      if (ORDER_SRC == ORDER_LINEAR) begin : g_fixed_lin
         assign use_xor = 1'b0;
      end else if (ORDER_SRC == ORDER_XOR) begin : g_fixed_xor
         assign use_xor = 1'b1;
      end else begin : g_pin
         assign use_xor = order_sel;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         seed_q <= '0;
         beat_q <= '0;
      end else if (load) begin
         seed_q <= seed;
         beat_q <= '0;
      end else if (step) begin
         beat_q <= beat_q + ONE;
      end
   end

   assign offset = use_xor ? (seed_q ^ beat_q) : (seed_q + beat_q);

   // R6: in interleaved order consecutive offsets differ by beat XOR (beat+1)
   assert_xor_step_R6: assert property (@(posedge clk) disable iff (rst)
      (step && !load && use_xor) |=>
         (!use_xor || ((offset ^ $past(offset)) == ($past(beat_q) ^ ($past(beat_q) + ONE)))));

   // R7: in linear order each step adds one modulo the burst length
   assert_linear_step_R7: assert property (@(posedge clk) disable iff (rst)
      (step && !load && !use_xor) |=> (use_xor || (offset == $past(offset) + ONE)));
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
   import burst_seq_pkg::*;
#(
   parameter int ADDR_W    = 17,
   parameter int BURST_W   = 2,
   parameter int ORDER_SRC = ORDER_FROM_PIN
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              proc_stb_n,
   input  logic              ctrl_stb_n,
   input  logic              adv_n,
   input  logic              order_sel,
   input  logic              sel1_n,
   input  logic              sel2,
   input  logic              sel3_n,
   input  logic [ADDR_W-1:0] addr_in,
   output logic [ADDR_W-1:0] addr_out,
   output logic              active,
   output logic              proc_owned
);
   localparam int UPPER_W = ADDR_W - BURST_W;

   generate
      if (BURST_W < 1 || BURST_W >= ADDR_W) begin : g_bad_width
         $error("burst_addr_seq: BURST_W must be at least 1 and below ADDR_W");
      end
      if (ORDER_SRC < ORDER_FROM_PIN || ORDER_SRC > ORDER_XOR) begin : g_bad_order
         $error("burst_addr_seq: ORDER_SRC out of range");
      end
   endgenerate

   cyc_kind_e           kind;
   logic                from_proc;
   logic                step;
   logic [UPPER_W-1:0]  upper_q;
   logic [BURST_W-1:0]  offset;

   burst_strobe_arb u_arb (
      .proc_stb_n (proc_stb_n),
      .ctrl_stb_n (ctrl_stb_n),
      .sel1_n     (sel1_n),
      .sel2       (sel2),
      .sel3_n     (sel3_n),
      .kind       (kind),
      .from_proc  (from_proc)
   );

   assign step = (kind == CYC_NONE) && active && !adv_n;

   burst_wrap_ctr #(
      .BURST_W   (BURST_W),
      .ORDER_SRC (ORDER_SRC)
   ) u_ctr (
      .clk       (clk),
      .rst       (rst),
      .load      (kind == CYC_LOAD),
      .seed      (addr_in[BURST_W-1:0]),
      .step      (step),
      .order_sel (order_sel),
      .offset    (offset)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         upper_q    <= '0;
         active     <= 1'b0;
         proc_owned <= 1'b0;
      end else begin
         case (kind)
            CYC_LOAD: begin
               upper_q    <= addr_in[ADDR_W-1:BURST_W];
               active     <= 1'b1;
               proc_owned <= from_proc;
            end
            CYC_DESEL: begin
               active     <= 1'b0;
               proc_owned <= 1'b0;
            end
            default: ;
         endcase
      end
   end

   assign addr_out = {upper_q, offset};

   // R2: a selected start shows the full captured address and raises active
   assert_load_addr_R2: assert property (@(posedge clk) disable iff (rst)
      (kind == CYC_LOAD) |=> (active && addr_out == $past(addr_in)));

   // R3: both strobes with chip enable 1 low is a processor-owned cycle
   assert_proc_priority_R3: assert property (@(posedge clk) disable iff (rst)
      (!proc_stb_n && !ctrl_stb_n && !sel1_n && sel2 && !sel3_n) |=> proc_owned);

   // R5: a strobe while deselected closes the burst and keeps the address
   assert_desel_close_R5: assert property (@(posedge clk) disable iff (rst)
      (kind == CYC_DESEL) |=> (!active && !proc_owned && $stable(addr_out)));

   // R8: suspend holds the address (unless the order pin moved)
   assert_suspend_hold_R8: assert property (@(posedge clk) disable iff (rst)
      (kind == CYC_NONE && adv_n) |=> (!$stable(order_sel) || $stable(addr_out)));

   // R10: outside a load the upper address bits never move
   assert_upper_frozen_R10: assert property (@(posedge clk) disable iff (rst)
      (kind != CYC_LOAD) |=> $stable(addr_out[ADDR_W-1:BURST_W]));

   // R11: no stepping while no burst is active
   assert_idle_no_step_R11: assert property (@(posedge clk) disable iff (rst)
      (kind == CYC_NONE && !active) |=> (!$stable(order_sel) || $stable(addr_out)));
endmodule

// File: tb/burst_addr_seq_bench.sv
module burst_addr_seq_bench;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        proc_stb_n = 1'b1;
   logic        ctrl_stb_n = 1'b1;
   logic        adv_n = 1'b1;
   logic        order_sel = 1'b0;
   logic        sel1_n = 1'b0;
   logic        sel2 = 1'b1;
   logic        sel3_n = 1'b0;
   logic [16:0] addr_in = '0;
   logic [16:0] addr_out;
   logic        active;
   logic        proc_owned;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   burst_addr_seq u_burst_addr_seq (
      .clk        (clk),
      .rst        (rst),
      .proc_stb_n (proc_stb_n),
      .ctrl_stb_n (ctrl_stb_n),
      .adv_n      (adv_n),
      .order_sel  (order_sel),
      .sel1_n     (sel1_n),
      .sel2       (sel2),
      .sel3_n     (sel3_n),
      .addr_in    (addr_in),
      .addr_out   (addr_out),
      .active     (active),
      .proc_owned (proc_owned)
   );

   task automatic chk(input string req, input logic [16:0] got, input logic [16:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   // Apply the current inputs across one rising edge, then wait for the settled outputs.
   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic idle_inputs();
      proc_stb_n = 1'b1; ctrl_stb_n = 1'b1; adv_n = 1'b1;
      sel1_n = 1'b0; sel2 = 1'b1; sel3_n = 1'b0;
   endtask

   task automatic start_burst(input bit by_proc, input logic [16:0] a);
      @(negedge clk);
      idle_inputs();
      addr_in = a;
      if (by_proc) proc_stb_n = 1'b0; else ctrl_stb_n = 1'b0;
      tick();
   endtask

   initial begin
      logic [16:0] base;
      logic [16:0] held;
      logic [1:0]  off;
      int          beat;

      // R1: reset state
      tick(); tick();
      chk("R1 addr", addr_out, 17'h0);
      chk("R1 active", {16'h0, active}, 17'h1 & 17'h0);
      chk("R1 owner", {16'h0, proc_owned}, 17'h0);
      @(negedge clk); rst = 1'b0;

      // R11: advance while idle must not move the address
      @(negedge clk); idle_inputs(); adv_n = 1'b0; tick();
      chk("R11 idle advance", addr_out, 17'h0);

      // Sweep: order x strobe x start offset, five beats with a suspend and scrambled enables.
      for (int m = 0; m < 2; m++) begin
         for (int s = 0; s < 2; s++) begin
            for (int st = 0; st < 4; st++) begin
               base = 17'((m * 8 + s * 4 + st) * 4 + 17'h1A5C0) | 17'(st);
               order_sel = m[0];
               start_burst(s[0], base);
               chk("R2 load addr", addr_out, base);
               chk("R2 active", {16'h0, active}, 17'h1);
               chk("R3 owner", {16'h0, proc_owned}, {16'h0, s[0]});
               beat = 0;
               for (int k = 1; k <= 5; k++) begin
                  @(negedge clk);
                  idle_inputs();
                  // R9: scramble chip enables during continue/suspend cycles
                  sel1_n = k[0]; sel2 = k[1]; sel3_n = ~k[0];
                  if (k == 3) begin
                     adv_n = 1'b1;
                     held = addr_out;
                     tick();
                     chk("R8 suspend hold", addr_out, held);
                     @(negedge clk);
                     sel1_n = 1'b1; sel2 = 1'b0; sel3_n = 1'b1;
                  end
                  adv_n = 1'b0;
                  tick();
                  beat++;
                  off = (m == 1) ? (2'(st) ^ 2'(beat)) : 2'(st + beat);
                  chk(m == 1 ? "R6 interleave beat" : "R7 linear beat",
                      addr_out, {base[16:2], off});
                  chk("R9 active kept", {16'h0, active}, 17'h1);
               end
               // R10: after five advances the offset equals start+1 beat; upper bits unchanged
               chk("R10 upper frozen", {addr_out[16:2], 2'b00}, {base[16:2], 2'b00});
            end
         end
      end

      // R10: four advances return to the start address (linear)
      order_sel = 1'b0;
      start_burst(1'b0, 17'h0FFFF);
      @(negedge clk); idle_inputs(); adv_n = 1'b0;
      for (int k = 0; k < 4; k++) tick();
      chk("R10 wrap", addr_out, 17'h0FFFF);

      // R4: masked processor strobe with chip enable 1 high, suspend: nothing changes
      @(negedge clk); idle_inputs();
      sel1_n = 1'b1; proc_stb_n = 1'b0; addr_in = 17'h12345;
      tick();
      chk("R4 masked addr", addr_out, 17'h0FFFF);
      chk("R4 masked active", {16'h0, active}, 17'h1);
      // R4: masked processor strobe while advancing continues the burst
      @(negedge clk); adv_n = 1'b0; tick();
      chk("R4 masked continue", addr_out, 17'h0FFFC);

      // R3: both strobes low and selected -> processor owns it
      @(negedge clk); idle_inputs();
      proc_stb_n = 1'b0; ctrl_stb_n = 1'b0; addr_in = 17'h00102;
      tick();
      chk("R3 both owner", {16'h0, proc_owned}, 17'h1);
      chk("R3 both addr", addr_out, 17'h00102);

      // R5: processor strobe with chip enable 2 low -> deselect, address kept
      @(negedge clk); idle_inputs();
      proc_stb_n = 1'b0; sel2 = 1'b0; addr_in = 17'h1FFFF;
      tick();
      chk("R5 desel active", {16'h0, active}, 17'h0);
      chk("R5 desel owner", {16'h0, proc_owned}, 17'h0);
      chk("R5 desel addr", addr_out, 17'h00102);

      // R11: no stepping after deselect
      @(negedge clk); idle_inputs(); adv_n = 1'b0; tick();
      chk("R11 after desel", addr_out, 17'h00102);

      // R5: controller strobe with chip enable 1 high -> deselect
      start_burst(1'b0, 17'h00040);
      @(negedge clk); idle_inputs();
      ctrl_stb_n = 1'b0; sel1_n = 1'b1; addr_in = 17'h00777;
      tick();
      chk("R5 ctrl desel active", {16'h0, active}, 17'h0);
      chk("R5 ctrl desel addr", addr_out, 17'h00040);

      // R1: reset in the middle of a burst
      start_burst(1'b1, 17'h15555);
      @(negedge clk); idle_inputs(); rst = 1'b1; tick();
      chk("R1 mid reset addr", addr_out, 17'h0);
      chk("R1 mid reset active", {16'h0, active}, 17'h0);
      @(negedge clk); rst = 1'b0;

      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule